// File: doc/BRIEF.md
# 100BASE-TX Transmit PCS Encoder

This block takes the nibble stream of a media-independent transmit interface and turns it into the line-state sequence of a 100 Mb/s twisted-pair transmitter. Each sampled nibble becomes a 5-bit code group. A frame opens with a start-delimiter pair and closes with an end-delimiter pair. An error request inside a frame becomes a halt symbol, and IDLE fills every gap between frames. The code groups are serialized most significant bit first. The serial stream is scrambled by an 11-bit LFSR and then mapped onto a three-level MLT-3 code.

The block runs on a single bit-rate clock, five clocks per nibble. A one-cycle take strobe marks the clock edge on which the nibble inputs are sampled, and the upstream logic presents a new nibble in that cycle. The block also produces registered carrier-sense and collision outputs. These are derived from the transmit request, a receive-busy indication from the receive side, and the duplex setting.

Top module: `fe_tx_pcs`

## Requirements
- R1: `nib_take` is high for one clock in every five. It first rises in the fourth clock cycle after reset is released. The nibble inputs are sampled on the rising edge at the end of each cycle in which `nib_take` is high.
- R2: When `nib_valid` is low at a sample and no frame is in progress, the code group is IDLE (11111). A `nib_error` without `nib_valid` has no effect.
- R3: The first sample with `nib_valid` high after IDLE yields J (11000). The next sample yields K (10001). In both cases the nibble data and `nib_error` are ignored.
- R4: Later samples with `nib_valid` high and `nib_error` low encode the data nibble as follows (hex data to group): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R5: A data-phase sample with `nib_valid` and `nib_error` both high yields HALT (00100).
- R6: The first data-phase sample with `nib_valid` low yields T (01101). The sample after it yields R (00111) whatever the inputs are. The sample after that is treated as the start of the gap between frames.
- R7: A group loaded at a sample edge leaves at one bit per clock, MSB first, on the following five edges. Each bit is XORed with the feedback `s[10]^s[8]` of an 11-bit LFSR. On every clock the LFSR shifts left, taking that feedback in as its new bit 0 (polynomial x^11+x^9+1). Reset sets all LFSR bits to one.
- R8: `line_lvl` encodes the line state as 00 for zero, 01 for plus and 11 for minus. Each scrambled 1 bit steps the state through zero, plus, zero, minus and back to zero. Each scrambled 0 bit holds the state. Reset starts at the zero that precedes plus. `line_lvl` reflects all bits sent up to the last edge.
- R9: `carrier` is registered. In half duplex (`full_dpx` low) it is the OR of `nib_valid` and `rx_busy`. In full duplex it follows `rx_busy` only.
- R10: `collide` is registered. It is high only in half duplex, when `nib_valid` and `rx_busy` are both high. It is never high in full duplex.
- R11: During reset, `line_lvl` is 00 and `nib_take`, `carrier` and `collide` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, five cycles per nibble |
| rst | input | 1 | Synchronous active-high reset |
| nib_data | input | 4 | Transmit data nibble |
| nib_valid | input | 1 | Transmit request; frame in progress |
| nib_error | input | 1 | Transmit error request |
| rx_busy | input | 1 | Receive activity from the receive side |
| full_dpx | input | 1 | 1 selects full duplex |
| nib_take | output | 1 | Nibble inputs sampled at the end of this cycle |
| line_lvl | output | 2 | MLT-3 line state (00 zero, 01 plus, 11 minus) |
| carrier | output | 1 | Carrier sense |
| collide | output | 1 | Collision indication |

## Verification
The assertions assume that reset is held until the first clock edge. They also assume that the nibble inputs only carry meaning on take edges, while `nib_valid` may change on any cycle for the carrier logic. The bench drives all inputs at falling edges, so every value is stable at the sampling edge. It changes the nibble inputs only while the take strobe is high, except in the final carrier and collision sweep. That sweep changes the request every cycle, and line checking is switched off for it.

// File: rtl/fe_tx_pcs_pkg.sv
package fe_tx_pcs_pkg;

    localparam int NIB_W    = 4;
    localparam int GRP_W    = 5;
    localparam int CNT_W    = $clog2(GRP_W);
    localparam int SCR_LEN  = 11;
    localparam int SCR_TAP  = 9;
    localparam logic [SCR_LEN-1:0] SCR_SEED = '1;

    typedef logic [GRP_W-1:0] grp_t;

    localparam grp_t CG_IDLE = 5'b11111;
    localparam grp_t CG_J    = 5'b11000;
    localparam grp_t CG_K    = 5'b10001;
    localparam grp_t CG_T    = 5'b01101;
    localparam grp_t CG_R    = 5'b00111;
    localparam grp_t CG_HALT = 5'b00100;

    localparam logic [1:0] LINE_ZERO = 2'b00;
    localparam logic [1:0] LINE_POS  = 2'b01;
    localparam logic [1:0] LINE_NEG  = 2'b11;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_K    = 2'd1,
        FR_DATA = 2'd2,
        FR_R    = 2'd3
    } frame_st_e;

    typedef struct packed {
        logic             valid;
        logic             error;
        logic [NIB_W-1:0] data;
    } mii_nib_t;

    function automatic grp_t enc_4b5b(input logic [NIB_W-1:0] d);
        grp_t g;
        case (d)
            4'h0: g = 5'b11110;
            4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;
            4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;
            4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;
            4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;
            4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;
            4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;
            4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;
            default: g = 5'b11101;
        endcase
        return g;
    endfunction

    // Phase 0 and 2 are both zero level; 1 is plus, 3 is minus.
    function automatic logic [1:0] phase_to_line(input logic [1:0] ph);
        logic [1:0] l;
        case (ph)
            2'd1:    l = LINE_POS;
            2'd3:    l = LINE_NEG;
            default: l = LINE_ZERO;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/fe_tx_group_sel.sv
module fe_tx_group_sel
    import fe_tx_pcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mii_nib_t nib,
    output logic     take,
    output grp_t     grp
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP_W - 1);

    logic [CNT_W-1:0] cnt;
    frame_st_e        st;
    frame_st_e        st_nx;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (cnt == CNT_LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign take = (cnt == CNT_LAST);

    always_comb begin
        st_nx = st;
        grp   = CG_IDLE;
        case (st)
            FR_IDLE: begin
                if (nib.valid) begin
                    grp   = CG_J;
                    st_nx = FR_K;
                end
            end
            FR_K: begin
                grp   = CG_K;
                st_nx = FR_DATA;
            end
            FR_DATA: begin
                if (!nib.valid) begin
                    grp   = CG_T;
                    st_nx = FR_R;
                end else if (nib.error) begin
                    grp = CG_HALT;
                end else begin
                    grp = enc_4b5b(nib.data);
                end
            end
            default: begin
                grp   = CG_R;
                st_nx = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       st <= FR_IDLE;
        else if (take) st <= st_nx;
    end

    assert_take_gap_R1: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    assert_frame_open_R3: assert property (@(posedge clk) disable iff (rst)
        (take && st == FR_IDLE && nib.valid) |=> (st == FR_K));

    assert_tail_close_R6: assert property (@(posedge clk) disable iff (rst)
        (take && st == FR_R) |=> (st == FR_IDLE));

endmodule

// File: rtl/fe_tx_serial_scr.sv
module fe_tx_serial_scr
    import fe_tx_pcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  grp_t grp,
    output logic sbit
);

    grp_t               sr;
    logic [SCR_LEN-1:0] lfsr;
    logic               fb;

    assign fb   = lfsr[SCR_LEN-1] ^ lfsr[SCR_TAP-1];
    assign sbit = sr[GRP_W-1] ^ fb;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= CG_IDLE;
            lfsr <= SCR_SEED;
        end else begin
            lfsr <= {lfsr[SCR_LEN-2:0], fb};
            if (load) sr <= grp;
            else      sr <= {sr[GRP_W-2:0], 1'b0};
        end
    end

    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);

endmodule

// File: rtl/fe_tx_mlt3.sv
module fe_tx_mlt3
    import fe_tx_pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sbit,
    output logic [1:0] line
);

    logic [1:0] ph;

    always_ff @(posedge clk) begin
        if (rst)       ph <= 2'd0;
        else if (sbit) ph <= ph + 2'd1;
    end

    assign line = phase_to_line(ph);

    assert_hold_on_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !sbit |=> $stable(line));

    assert_no_jump_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(line) == LINE_POS) |-> (line != LINE_NEG));

endmodule

// File: rtl/fe_tx_carrier.sv
module fe_tx_carrier (
    input  logic clk,
    input  logic rst,
    input  logic tx_req,
    input  logic rx_busy,
    input  logic full_dpx,
    output logic carrier,
    output logic collide
);

    always_ff @(posedge clk) begin
        if (rst) begin
            carrier <= 1'b0;
            collide <= 1'b0;
        end else begin
            carrier <= rx_busy | (tx_req & ~full_dpx);
            collide <= tx_req & rx_busy & ~full_dpx;
        end
    end

    assert_rx_sense_R9: assert property (@(posedge clk) disable iff (rst)
        rx_busy |=> carrier);

    assert_fdx_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        full_dpx |=> !collide);

endmodule

// File: rtl/fe_tx_pcs.sv
module fe_tx_pcs
    import fe_tx_pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib_data,
    input  logic             nib_valid,
    input  logic             nib_error,
    input  logic             rx_busy,
    input  logic             full_dpx,
    output logic             nib_take,
    output logic [1:0]       line_lvl,
    output logic             carrier,
    output logic             collide
);

    mii_nib_t nib;
    grp_t     grp;
    logic     sbit;

    assign nib = '{valid: nib_valid, error: nib_error, data: nib_data};

    fe_tx_group_sel u_sel (
        .clk  (clk),
        .rst  (rst),
        .nib  (nib),
        .take (nib_take),
        .grp  (grp)
    );

    fe_tx_serial_scr u_scr (
        .clk  (clk),
        .rst  (rst),
        .load (nib_take),
        .grp  (grp),
        .sbit (sbit)
    );

    fe_tx_mlt3 u_mlt (
        .clk  (clk),
        .rst  (rst),
        .sbit (sbit),
        .line (line_lvl)
    );

    fe_tx_carrier u_crs (
        .clk      (clk),
        .rst      (rst),
        .tx_req   (nib_valid),
        .rx_busy  (rx_busy),
        .full_dpx (full_dpx),
        .carrier  (carrier),
        .collide  (collide)
    );

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> (line_lvl == LINE_ZERO && !carrier && !collide));

endmodule

// File: tb/fe_tx_pcs_bench.sv
`timescale 1ns/1ps
module fe_tx_pcs_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nib_data = '0;
    logic       nib_valid = 1'b0;
    logic       nib_error = 1'b0;
    logic       rx_busy = 1'b0;
    logic       full_dpx = 1'b0;
    logic       nib_take;
    logic [1:0] line_lvl;
    logic       carrier;
    logic       collide;

    always #4 clk = ~clk;

    fe_tx_pcs u_fe_tx_pcs (
        .clk(clk), .rst(rst), .nib_data(nib_data), .nib_valid(nib_valid),
        .nib_error(nib_error), .rx_busy(rx_busy), .full_dpx(full_dpx),
        .nib_take(nib_take), .line_lvl(line_lvl), .carrier(carrier),
        .collide(collide)
    );

    typedef struct packed {
        logic       en;
        logic       er;
        logic [3:0] d;
        logic [4:0] g;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'h0, 5'b11111, 4'd2},  // R2 idle
        '{1'b0, 1'b0, 4'h0, 5'b11111, 4'd2},  // R2 idle
        '{1'b0, 1'b1, 4'h5, 5'b11111, 4'd2},  // R2 error alone ignored
        '{1'b1, 1'b0, 4'h5, 5'b11000, 4'd3},  // R3 J
        '{1'b1, 1'b1, 4'h5, 5'b10001, 4'd3},  // R3 K, error ignored
        '{1'b1, 1'b0, 4'h0, 5'b11110, 4'd4},  // R4 data
        '{1'b1, 1'b0, 4'h1, 5'b01001, 4'd4},
        '{1'b1, 1'b0, 4'h2, 5'b10100, 4'd4},
        '{1'b1, 1'b0, 4'h3, 5'b10101, 4'd4},
        '{1'b1, 1'b0, 4'h4, 5'b01010, 4'd4},
        '{1'b1, 1'b0, 4'h5, 5'b01011, 4'd4},
        '{1'b1, 1'b0, 4'h6, 5'b01110, 4'd4},
        '{1'b1, 1'b0, 4'h7, 5'b01111, 4'd4},
        '{1'b1, 1'b0, 4'h8, 5'b10010, 4'd4},
        '{1'b1, 1'b0, 4'h9, 5'b10011, 4'd4},
        '{1'b1, 1'b0, 4'hA, 5'b10110, 4'd4},
        '{1'b1, 1'b0, 4'hB, 5'b10111, 4'd4},
        '{1'b1, 1'b0, 4'hC, 5'b11010, 4'd4},
        '{1'b1, 1'b0, 4'hD, 5'b11011, 4'd4},
        '{1'b1, 1'b0, 4'hE, 5'b11100, 4'd4},
        '{1'b1, 1'b0, 4'hF, 5'b11101, 4'd4},
        '{1'b1, 1'b1, 4'h3, 5'b00100, 4'd5},  // R5 halt
        '{1'b1, 1'b0, 4'h9, 5'b10011, 4'd4},
        '{1'b0, 1'b0, 4'h0, 5'b01101, 4'd6},  // R6 T
        '{1'b1, 1'b0, 4'h7, 5'b00111, 4'd6},  // R6 R, request ignored
        '{1'b1, 1'b0, 4'h5, 5'b11000, 4'd3},  // R3 J
        '{1'b1, 1'b0, 4'h5, 5'b10001, 4'd3},  // R3 K
        '{1'b0, 1'b0, 4'h0, 5'b01101, 4'd6},  // R6 T
        '{1'b0, 1'b0, 4'h0, 5'b00111, 4'd6},  // R6 R
        '{1'b0, 1'b0, 4'h0, 5'b11111, 4'd2},  // R2 idle
        '{1'b0, 1'b1, 4'hF, 5'b11111, 4'd2}   // R2 error alone ignored
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit line_chk = 1'b0;

    // Reference stream model built from R7 and R8.
    logic [4:0]  m_cur, m_next;
    logic [10:0] m_lfsr;
    logic [1:0]  m_ph;
    int          m_idx, m_tag, m_ntag, m_btag;

    always @(posedge clk) begin
        logic b, fb;
        if (rst) begin
            m_cur = 5'b11111; m_lfsr = '1; m_ph = 2'd0; m_idx = 0;
            m_tag = 2; m_btag = 2;
        end else begin
            b  = m_cur[4 - m_idx];
            fb = m_lfsr[10] ^ m_lfsr[8];
            m_lfsr = {m_lfsr[9:0], fb};
            if (b ^ fb) m_ph = m_ph + 2'd1;
            m_btag = m_tag;
            if (m_idx == 4) begin
                m_idx = 0; m_cur = m_next; m_tag = m_ntag;
            end else begin
                m_idx = m_idx + 1;
            end
        end
    end

    function automatic logic [1:0] exp_line(input logic [1:0] ph);
        case (ph)
            2'd1:    return 2'b01;
            2'd3:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        if (line_chk)
            check(line_lvl === exp_line(m_ph), $sformatf("R%0d", m_btag),
                  "line_lvl", int'(line_lvl), int'(exp_line(m_ph)));
    endtask

    task automatic present(input logic en, input logic er, input logic [3:0] d,
                           input logic [4:0] g, input int rq);
        while (nib_take !== 1'b1) cycle();
        nib_valid = en; nib_error = er; nib_data = d;
        m_next = g; m_ntag = rq;
        cycle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int wait_n, changes;
        logic [1:0] prev;
        m_next = 5'b11111; m_ntag = 2;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(line_lvl === 2'b00, "R11", "line_lvl", int'(line_lvl), 0);
        check(carrier === 1'b0, "R11", "carrier", int'(carrier), 0);
        check(collide === 1'b0, "R11", "collide", int'(collide), 0);
        check(nib_take === 1'b0, "R11", "nib_take", int'(nib_take), 0);
        rst = 1'b0;
        line_chk = 1'b1;

        // R1 take timing: first at the 4th cycle, then every 5
        wait_n = 0;
        while (nib_take !== 1'b1 && wait_n < 20) begin cycle(); wait_n++; end
        check(wait_n == 4, "R1", "first take delay", wait_n, 4);
        wait_n = 0;
        cycle(); wait_n++;
        while (nib_take !== 1'b1 && wait_n < 20) begin cycle(); wait_n++; end
        check(wait_n == 5, "R1", "take period", wait_n, 5);

        // R7 idle is scrambled: line is not constant
        changes = 0;
        prev = line_lvl;
        for (int i = 0; i < 20; i++) begin
            cycle();
            if (line_lvl !== prev) changes++;
            prev = line_lvl;
        end
        check(changes > 0, "R7", "idle line changes", changes, 1);

        // Table of frames: R2..R8 through the line stream
        for (int i = 0; i < NV; i++)
            present(VECS[i].en, VECS[i].er, VECS[i].d, VECS[i].g, int'(VECS[i].rq));
        for (int i = 0; i < 3; i++) present(1'b0, 1'b0, 4'h0, 5'b11111, 2);
        repeat (6) cycle();

        // R9 / R10 carrier and collision sweep
        line_chk = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            full_dpx = i[2]; nib_valid = i[1]; rx_busy = i[0];
            @(negedge clk);
            check(carrier === (i[2] ? i[0] : (i[1] | i[0])), "R9", "carrier",
                  int'(carrier), int'(i[2] ? i[0] : (i[1] | i[0])));
            check(collide === (!i[2] && i[1] && i[0]), "R10", "collide",
                  int'(collide), int'(!i[2] && i[1] && i[0]));
        end
        finish_run();
    end

endmodule